// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides whether a 16550-style UART asks the host for service and which cause it reports. It watches four causes: receive line errors, received data reaching the programmed trigger depth, data left waiting unread for too long, and the transmit holding register becoming empty. It combines them with the host's enable mask and a fixed priority. It then presents a registered interrupt line and a registered identification byte that the host reads to learn the cause.

Each cause is cleared by the host action that answers it. A status read clears the error cause. Draining the receive FIFO removes the data cause. Reading the receive buffer or pushing a new character restarts the idle timer. Writing the transmit holding register clears the empty cause. Reading the identification byte also clears the empty cause, but only while that is the cause it reports. The FIFO storage, the shifters and the baud generator sit outside. They supply the fill level, a push strobe, a pulse once per character time, and the error and empty events.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, `iirOut` is 0xC1 and `irqOut` is 0.
- R2: The identification byte is 0xC6 for a line error, 0xC4 for receive data at trigger depth, 0xCC for character timeout and 0xC2 for transmit holding empty. Bits 7:6 are always 1, and bit 0 is 0 whenever a cause is reported.
- R3: `ierIn` bit 0 enables the receive data and timeout causes, bit 1 enables transmit empty, and bit 2 enables line error. A disabled cause is not reported but stays pending, and it is reported once its enable is set.
- R4: With several causes reported at once, the priority is line error, then receive data, then timeout, then transmit empty.
- R5: A `thrWrite` strobe clears a pending transmit-empty cause.
- R6: An `iirRead` strobe clears the transmit-empty cause only while `iirOut` is 0xC2. Otherwise it leaves that cause pending.
- R7: Any bit of `errPulse` sets the line-error cause, and `lsrRead` clears it. A new error in the same cycle as the read keeps the cause set.
- R8: `trigIdx` values 0, 1, 2 and 3 select trigger depths of 1, 4, 8 and 14 characters. The receive data cause holds while `rxLevel` is at or above the depth.
- R9: While `rxLevel` is nonzero, each `charTick` pulse advances an idle count that saturates at TIMEOUT_CHARS (default 4). The timeout cause holds while the count is at that limit and the FIFO is non-empty.
- R10: The idle count returns to zero on `rxPush`, on `rbrRead`, or whenever `rxLevel` is zero.
- R11: `irqOut` and `iirOut` are registered. A change in a level input shows one clock later, and a strobe that sets or clears a cause shows two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ierIn | input | 3 | Interrupt enable mask |
| trigIdx | input | 2 | Receive trigger depth select |
| rxLevel | input | LEVEL_W | Characters currently held in the receive FIFO |
| rxPush | input | 1 | A character entered the receive FIFO |
| rbrRead | input | 1 | Host read of the receive buffer |
| charTick | input | 1 | One pulse per character time |
| errPulse | input | ERR_W | Receive error events (overrun, parity, framing, break) |
| lsrRead | input | 1 | Host read of line status |
| threEvent | input | 1 | Transmit holding register became empty |
| thrWrite | input | 1 | Host write of the transmit holding register |
| iirRead | input | 1 | Host read of the identification byte |
| irqOut | output | 1 | Interrupt request |
| iirOut | output | 8 | Identification byte |

## Verification
The priority encoder is driven with single causes and with overlapping causes. Single causes check each code and each enable bit alone. Overlapping causes separate a correct priority order from a swapped one, and they separate a clear that is conditional on the reported cause from one that is not. Fill levels one below and exactly at each of the four trigger depths separate the depth table from neighbouring entries. The tick sequences stop one short of, at, and beyond the timeout limit, and they are cut by a push, by a buffer read and by an empty FIFO. These runs show both when the idle count counts and when it restarts.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Identification byte codes: bits 7:6 set, bit 0 low when a cause is reported
  localparam logic [7:0] IIR_NONE    = 8'hC1;
  localparam logic [7:0] IIR_LINE    = 8'hC6;
  localparam logic [7:0] IIR_RXDATA  = 8'hC4;
  localparam logic [7:0] IIR_TIMEOUT = 8'hCC;
  localparam logic [7:0] IIR_THRE    = 8'hC2;

  // Enable mask bit positions
  localparam int EN_RX   = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LINE = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic lineSet;
    logic lineClr;
    logic threSet;
    logic threKill;   // host write: overrides a simultaneous set
    logic threClr;    // identification read of an empty cause
    logic cntClear;
    logic cntStep;
  } irqStrobes_t;

  function automatic logic [4:0] trigDepth(input logic [1:0] idx);
    case (idx)
      2'd0:    trigDepth = 5'd1;
      2'd1:    trigDepth = 5'd4;
      2'd2:    trigDepth = 5'd8;
      default: trigDepth = 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic [2:0]       ierIn,
  input  logic [ERR_W-1:0] errPulse,
  input  logic             lsrRead,
  input  logic             iirRead,
  input  logic             thrWrite,
  input  logic             threEvent,
  input  logic             rxPush,
  input  logic             rbrRead,
  input  logic             charTick,
  input  logic             linePend,
  input  logic             threPend,
  input  logic             rxAvail,
  input  logic             rxNonEmpty,
  input  logic             toHit,
  input  logic [7:0]       iirQ,
  output irqStrobes_t      strb,
  output logic [7:0]       iirNext,
  output logic             irqNext
);

  logic lineOn, rxOn, toOn, threOn;

  always_comb begin
    strb          = '0;
    strb.lineSet  = |errPulse;
    strb.lineClr  = lsrRead;
    strb.threSet  = threEvent;
    strb.threKill = thrWrite;
    strb.threClr  = iirRead && (iirQ == IIR_THRE);
    strb.cntClear = rxPush || rbrRead || !rxNonEmpty;
    strb.cntStep  = charTick && rxNonEmpty;
  end

  assign lineOn = ierIn[EN_LINE] && linePend;
  assign rxOn   = ierIn[EN_RX]   && rxAvail;
  assign toOn   = ierIn[EN_RX]   && toHit;
  assign threOn = ierIn[EN_THRE] && threPend;

  // Fixed priority encoder
  always_comb begin
    if (lineOn)      iirNext = IIR_LINE;
    else if (rxOn)   iirNext = IIR_RXDATA;
    else if (toOn)   iirNext = IIR_TIMEOUT;
    else if (threOn) iirNext = IIR_THRE;
    else             iirNext = IIR_NONE;
  end

  assign irqNext = lineOn || rxOn || toOn || threOn;

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int LEVEL_W       = 5,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        strb,
  input  logic [7:0]         iirNext,
  input  logic               irqNext,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [1:0]         trigIdx,
  output logic               linePend,
  output logic               threPend,
  output logic               rxAvail,
  output logic               rxNonEmpty,
  output logic               toHit,
  output logic [7:0]         iirQ,
  output logic               irqQ
);

  localparam int CNT_W = $clog2(TIMEOUT_CHARS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CHARS);

  logic [CNT_W-1:0] idleCnt;

  assign rxNonEmpty = (rxLevel != '0);
  assign rxAvail    = (32'(rxLevel) >= 32'(trigDepth(trigIdx)));
  assign toHit      = rxNonEmpty && (idleCnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linePend <= 1'b0;
      threPend <= 1'b0;
      idleCnt  <= '0;
      iirQ     <= IIR_NONE;
      irqQ     <= 1'b0;
    end else begin
      // line error: a new error wins over the clearing read
      if (strb.lineSet)      linePend <= 1'b1;
      else if (strb.lineClr) linePend <= 1'b0;

      // transmit empty: host write wins, then a new event, then the read clear
      if (strb.threKill)     threPend <= 1'b0;
      else if (strb.threSet) threPend <= 1'b1;
      else if (strb.threClr) threPend <= 1'b0;

      // saturating idle counter
      if (strb.cntClear)                          idleCnt <= '0;
      else if (strb.cntStep && idleCnt != CNT_MAX) idleCnt <= idleCnt + 1'b1;

      iirQ <= iirNext;
      irqQ <= irqNext;
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH    = 16,
  parameter  int ERR_W         = 4,
  parameter  int TIMEOUT_CHARS = 4,
  localparam int LEVEL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         ierIn,
  input  logic [1:0]         trigIdx,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               rxPush,
  input  logic               rbrRead,
  input  logic               charTick,
  input  logic [ERR_W-1:0]   errPulse,
  input  logic               lsrRead,
  input  logic               threEvent,
  input  logic               thrWrite,
  input  logic               iirRead,
  output logic               irqOut,
  output logic [7:0]         iirOut
);

  irqStrobes_t strb;
  logic [7:0]  iirNext;
  logic        irqNext;
  logic        linePend, threPend, rxAvail, rxNonEmpty, toHit;

  uart_irq_ctrl #(.ERR_W(ERR_W)) u_ctrl (
    .ierIn(ierIn), .errPulse(errPulse), .lsrRead(lsrRead), .iirRead(iirRead),
    .thrWrite(thrWrite), .threEvent(threEvent), .rxPush(rxPush),
    .rbrRead(rbrRead), .charTick(charTick), .linePend(linePend),
    .threPend(threPend), .rxAvail(rxAvail), .rxNonEmpty(rxNonEmpty),
    .toHit(toHit), .iirQ(iirOut), .strb(strb), .iirNext(iirNext),
    .irqNext(irqNext)
  );

  uart_irq_dp #(.LEVEL_W(LEVEL_W), .TIMEOUT_CHARS(TIMEOUT_CHARS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .iirNext(iirNext), .irqNext(irqNext),
    .rxLevel(rxLevel), .trigIdx(trigIdx), .linePend(linePend),
    .threPend(threPend), .rxAvail(rxAvail), .rxNonEmpty(rxNonEmpty),
    .toHit(toHit), .iirQ(iirOut), .irqQ(irqOut)
  );

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int ERR_W   = 4,
  parameter int LEVEL_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         ierIn,
  input logic [ERR_W-1:0]   errPulse,
  input logic               thrWrite,
  input logic               threEvent,
  input logic               iirRead,
  input logic [LEVEL_W-1:0] rxLevel,
  input logic [7:0]         iirOut,
  input logic               irqOut
);

  // R2: only the five legal codes ever appear
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    (iirOut == 8'hC1) || (iirOut == 8'hC2) || (iirOut == 8'hC4) ||
    (iirOut == 8'hC6) || (iirOut == 8'hCC));

  // R3: an all-zero mask never raises the request
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ierIn == 3'b000) |=> !irqOut);

  // R4: an enabled line error outranks every other cause
  a_r4_line_first: assert property (@(posedge clk) disable iff (!rstN)
    ((|errPulse) && ierIn[2]) ##1 ierIn[2] |=> (iirOut == 8'hC6));

  // R5: a holding-register write removes the empty cause
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> ##1 (iirOut != 8'hC2));

  // R6: reading the reported empty cause removes it
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (iirRead && (iirOut == 8'hC2) && !threEvent) ##1 !threEvent
      |=> (iirOut != 8'hC2));

  // R9: an empty FIFO reports neither receive cause
  a_r9_empty_no_rx: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == '0) |=> ((iirOut != 8'hCC) && (iirOut != 8'hC4)));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.ERR_W(ERR_W), .LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .ierIn(ierIn), .errPulse(errPulse),
  .thrWrite(thrWrite), .threEvent(threEvent), .iirRead(iirRead),
  .rxLevel(rxLevel), .iirOut(iirOut), .irqOut(irqOut)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

  localparam int LEVEL_W = 5;

  typedef struct {
    logic [7:0] code;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] ierIn = '0;
  logic [1:0] trigIdx = '0;
  logic [LEVEL_W-1:0] rxLevel = '0;
  logic rxPush = 0, rbrRead = 0, charTick = 0, lsrRead = 0;
  logic threEvent = 0, thrWrite = 0, iirRead = 0;
  logic [3:0] errPulse = '0;
  logic irqOut;
  logic [7:0] iirOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  expItem_t expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rstN(rstN), .ierIn(ierIn), .trigIdx(trigIdx),
    .rxLevel(rxLevel), .rxPush(rxPush), .rbrRead(rbrRead),
    .charTick(charTick), .errPulse(errPulse), .lsrRead(lsrRead),
    .threEvent(threEvent), .thrWrite(thrWrite), .iirRead(iirRead),
    .irqOut(irqOut), .iirOut(iirOut)
  );

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (iirOut !== it.code || irqOut !== (it.code != 8'hC1)) begin
        fails++;
        $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
                 it.tag, iirOut, irqOut, it.code, (it.code != 8'hC1));
      end
    end
  end

  // Driver helpers: inputs change 1 ns after a rising edge
  task automatic strobe(input int which);
    case (which)
      0: threEvent = 1;
      1: thrWrite  = 1;
      2: iirRead   = 1;
      3: errPulse  = 4'b0100;
      4: lsrRead   = 1;
      5: charTick  = 1;
      6: rxPush    = 1;
      7: rbrRead   = 1;
      8: begin errPulse = 4'b0001; lsrRead = 1; end
      default: ;
    endcase
    @(posedge clk); #1;
    threEvent = 0; thrWrite = 0; iirRead = 0; errPulse = '0;
    lsrRead = 0; charTick = 0; rxPush = 0; rbrRead = 0;
  endtask

  task automatic expectIir(input logic [7:0] code, input string tag);
    @(posedge clk); #1;
    expQ.push_back('{code, tag});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) strobe(5);
  endtask

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    expectIir(8'hC1, "R1 reset idle");

    // R3: pending while disabled, reported once enabled
    strobe(0);
    expectIir(8'hC1, "R3 empty cause masked");
    ierIn = 3'b010;
    expectIir(8'hC2, "R3 masked cause reported after enable");
    // R6: identification read clears the reported empty cause
    strobe(2);
    expectIir(8'hC1, "R6 read clears empty");
    // R5: write clears
    strobe(0);
    expectIir(8'hC2, "R2 empty code");
    strobe(1);
    expectIir(8'hC1, "R5 write clears empty");

    // R8: trigger depths (ier all on, no ticks yet)
    ierIn = 3'b111;
    trigIdx = 2'd0; rxLevel = 5'd1;
    expectIir(8'hC4, "R8 depth 1 reached");
    trigIdx = 2'd1; rxLevel = 5'd3;
    expectIir(8'hC1, "R8 depth 4 below");
    rxLevel = 5'd4;
    expectIir(8'hC4, "R8 depth 4 reached");
    trigIdx = 2'd2; rxLevel = 5'd7;
    expectIir(8'hC1, "R8 depth 8 below");
    rxLevel = 5'd8;
    expectIir(8'hC4, "R8 depth 8 reached");
    trigIdx = 2'd3; rxLevel = 5'd13;
    expectIir(8'hC1, "R8 depth 14 below");
    rxLevel = 5'd14;
    expectIir(8'hC4, "R8 depth 14 reached");

    // R4 priority with all three causes
    strobe(0);
    expectIir(8'hC4, "R4 rx over empty");
    strobe(3);
    expectIir(8'hC6, "R4 line over rx");
    strobe(2);
    expectIir(8'hC6, "R6 read of other cause keeps state");
    strobe(8);
    expectIir(8'hC6, "R7 error wins over same-cycle clear");
    strobe(4);
    expectIir(8'hC4, "R7 status read clears line");
    rxLevel = 5'd0;
    expectIir(8'hC2, "R6 empty survived unrelated read");
    strobe(2);
    expectIir(8'hC1, "R6 read clears empty");

    // R3: line error masked
    ierIn = 3'b011;
    strobe(3);
    expectIir(8'hC1, "R3 line masked");
    ierIn = 3'b111;
    expectIir(8'hC6, "R3 line held while masked");
    strobe(4);
    expectIir(8'hC1, "R7 line cleared");

    // R9/R10 timeout
    trigIdx = 2'd3; rxLevel = 5'd2;
    ticks(3);
    expectIir(8'hC1, "R9 three ticks short");
    ticks(1);
    expectIir(8'hCC, "R9 timeout at limit");
    ticks(3);
    expectIir(8'hCC, "R9 count saturates");
    strobe(6);
    expectIir(8'hC1, "R10 push restarts count");
    ticks(4);
    expectIir(8'hCC, "R9 timeout again");
    strobe(7);
    expectIir(8'hC1, "R10 buffer read restarts count");
    ticks(2);
    rxLevel = 5'd0;
    ticks(5);
    rxLevel = 5'd2;
    ticks(2);
    expectIir(8'hC1, "R10 empty FIFO restarts count");
    ticks(2);
    expectIir(8'hCC, "R11 timeout after full count");
    ierIn = 3'b000;
    expectIir(8'hC1, "R11 level change one clock later");

    repeat (4) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule